// File: doc/BRIEF.md
# Zero-overhead hardware loop sequencer

This block holds the fetch program counter of a small processor and picks the next fetch address for every issued instruction. There are four sources: the sequential increment, a taken jump or call target, a reload to the loop start, and a hold when nothing issues. A repeat instruction arms the loop with a body length and an iteration count. Each later pass over the body goes back to its start with no extra cycle. The decision is the equivalent of a decrement-and-branch that costs nothing.

The loop state is an exit address, a start address, a remaining loop-back count and an active flag. Jumps and calls never cancel it. The only test is whether the next sequential address would reach the exit address. A flag registered one cycle ahead precomputes this test from whatever address is fetched next, so a jump that lands on the last body instruction still loops. A state-write port sets the start, the exit and the count directly. The state outputs let software save the loop and restore it later. When the start is set one past the exit address, the instruction at the exit address is skipped a counted number of times and then runs, which gives a counted breakpoint.

Decode, the register file and the memory are outside the block and appear only as stimulus ports.

Top module: `loop_seq`

## Requirements
- R1: While `rst` is high at a clock edge the block loads `fetch_pc`=0, `lp_start`=0, `lp_exit`=0, `lp_count`=0 and `lp_active`=0.
- R2: An issue with no jump, no repeat and no loop-back advances `fetch_pc` by one at the next edge. A cycle with `issue` low leaves `fetch_pc` unchanged.
- R3: An issued repeat at address P with length L and iteration count N loads `lp_start`=P+1 and `lp_exit`=P+1+L. If N>1 and L>0 it also loads `lp_count`=N-1 and `lp_active`=1. The next `fetch_pc` is P+1.
- R4: While `lp_active` is 1, issuing the instruction at `lp_exit`-1 with no jump makes the next `fetch_pc` equal `lp_start` at the very next edge and decrements `lp_count` by one. `lp_active` drops when the count reaches 0.
- R5: With no jumps, the body of an armed repeat runs exactly N times. Execution then continues at `lp_exit` with `lp_count`=0 and `lp_active`=0.
- R6: A taken jump loads `fetch_pc` with `jump_tgt`, even at `lp_exit`-1 of an active loop. On that cycle `lp_count` stays unchanged.
- R7: Jumps never cancel the loop. After leaving the body and jumping back, or jumping directly onto the last body instruction, the next pass at `lp_exit`-1 still loops back.
- R8: A repeat with N=0, N=1 or L=0 leaves `lp_active`=0 and `lp_count`=0, and the body runs once straight through.
- R9: When `st_we` is high, `st_sel`=0 writes `lp_start`, 1 writes `lp_exit` and 2 writes `lp_count`, all from `st_addr` or `st_cnt`. A count write sets `lp_active` to (`st_cnt`!=0). `st_sel`=3 changes nothing. A state write overrides the same field loaded by a repeat on the same cycle.
- R10: With `lp_start`=`lp_exit`+1 and `lp_count`=K, issuing at `lp_exit`-1 skips the instruction at `lp_exit` on K passes. On the next pass `fetch_pc` goes to `lp_exit`.
- R11: Reading the three state outputs and writing them back later through the state-write port resumes the loop with the same remaining passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue | input | 1 | The instruction at `fetch_pc` issues this cycle |
| jump_take | input | 1 | The issued instruction is a taken jump or call |
| jump_tgt | input | AW | Jump or call target |
| rep_go | input | 1 | The issued instruction is a repeat |
| rep_len | input | AW | Repeat body length in instructions |
| rep_iter | input | CW | Repeat iteration count |
| st_we | input | 1 | Loop-state write strobe |
| st_sel | input | 2 | Field select: 0 start, 1 exit, 2 count, 3 none |
| st_addr | input | AW | Address value for a start or exit write |
| st_cnt | input | CW | Value for a count write |
| fetch_pc | output | AW | Current fetch address |
| lp_start | output | AW | Loop start address |
| lp_exit | output | AW | Loop exit address (one past the last body instruction) |
| lp_count | output | CW | Remaining loop-backs |
| lp_active | output | 1 | Loop armed |
| loop_back | output | 1 | A loop-back is taken on this issue |

## Verification
If the precomputed end flag goes stale, a loop-back either comes one instruction late or never comes. Either way `fetch_pc` is wrong right after the issue of the last body instruction. A wrong count shows up as one pass too many or too few. It is first visible on `lp_count` at the loop-back edge and becomes a wrong fall-through address at the end of the loop. The bench follows every issued address through repeats of many lengths and counts. It also runs jump, breakpoint and save/restore sequences, so such a fault shows within one pass.

// File: rtl/loop_seq_pkg.sv
`timescale 1ns/1ps
package loop_seq_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_SEQ  = 2'd1,
    SRC_JUMP = 2'd2,
    SRC_LOOP = 2'd3
  } nxt_src_e;

  typedef enum logic [1:0] {
    FLD_START = 2'd0,
    FLD_EXIT  = 2'd1,
    FLD_COUNT = 2'd2,
    FLD_NONE  = 2'd3
  } st_field_e;
endpackage

// File: rtl/lseq_state.sv
`timescale 1ns/1ps
module lseq_state
  import loop_seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rep_fire,
  input  logic [AW-1:0] rep_base,
  input  logic [AW-1:0] rep_len,
  input  logic [CW-1:0] rep_iter,
  input  logic          loop_back,
  input  logic          st_we,
  input  logic [1:0]    st_sel,
  input  logic [AW-1:0] st_addr,
  input  logic [CW-1:0] st_cnt,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] exit_q,
  output logic [CW-1:0] count_q,
  output logic          active_q,
  output logic [AW-1:0] exit_nx
);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  function automatic logic arms(input logic [CW-1:0] n, input logic [AW-1:0] l);
    return (n > ONE_C) && (l != '0);
  endfunction

  function automatic logic [AW-1:0] exit_of(input logic [AW-1:0] b, input logic [AW-1:0] l);
    return b + l;
  endfunction

  logic [AW-1:0] start_nx;
  logic [CW-1:0] count_nx;
  logic          active_nx;
  st_field_e     fld;

  assign fld = st_field_e'(st_sel);

  always_comb begin
    start_nx  = start_q;
    exit_nx   = exit_q;
    count_nx  = count_q;
    active_nx = active_q;
    if (rep_fire) begin
      start_nx = rep_base;
      exit_nx  = exit_of(rep_base, rep_len);
      if (arms(rep_iter, rep_len)) begin
        count_nx  = rep_iter - ONE_C;
        active_nx = 1'b1;
      end else begin
        count_nx  = '0;
        active_nx = 1'b0;
      end
    end else if (loop_back) begin
      count_nx  = count_q - ONE_C;
      active_nx = (count_q != ONE_C);
    end
    if (st_we) begin
      case (fld)
        FLD_START: start_nx = st_addr;
        FLD_EXIT:  exit_nx  = st_addr;
        FLD_COUNT: begin
          count_nx  = st_cnt;
          active_nx = (st_cnt != '0);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= '0;
      exit_q   <= '0;
      count_q  <= '0;
      active_q <= 1'b0;
    end else begin
      start_q  <= start_nx;
      exit_q   <= exit_nx;
      count_q  <= count_nx;
      active_q <= active_nx;
    end
  end

  // R4
  active_matches_count_chk: assert property (@(posedge clk) disable iff (rst)
    active_q == (count_q != '0));

  // R4
  loop_back_decrements_chk: assert property (@(posedge clk) disable iff (rst)
    (loop_back && !st_we) |=> (count_q == $past(count_q) - ONE_C));

  // R4
  no_loop_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> !loop_back);
endmodule

// File: rtl/lseq_pc.sv
`timescale 1ns/1ps
module lseq_pc
  import loop_seq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          jump_take,
  input  logic [AW-1:0] jump_tgt,
  input  logic          rep_go,
  input  logic          active,
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] exit_q,
  input  logic [AW-1:0] exit_nx,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] seq_addr,
  output logic          loop_back,
  output nxt_src_e      src
);
  localparam logic [AW-1:0] ONE_A = AW'(1);

  function automatic logic [AW-1:0] step_of(input logic [AW-1:0] a);
    return a + ONE_A;
  endfunction

  logic          near_q;
  logic [AW-1:0] pc_nx;

  assign seq_addr  = step_of(pc_q);
  assign loop_back = issue && !jump_take && !rep_go && active && near_q;

  always_comb begin
    if (!issue)         src = SRC_HOLD;
    else if (jump_take) src = SRC_JUMP;
    else if (loop_back) src = SRC_LOOP;
    else                src = SRC_SEQ;
  end

  always_comb begin
    case (src)
      SRC_HOLD: pc_nx = pc_q;
      SRC_JUMP: pc_nx = jump_tgt;
      SRC_LOOP: pc_nx = start;
      default:  pc_nx = seq_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      near_q <= 1'b0;
    end else begin
      pc_q   <= pc_nx;
      near_q <= (step_of(pc_nx) == exit_nx);
    end
  end

  // R7
  near_flag_tracks_chk: assert property (@(posedge clk) disable iff (rst)
    near_q == (step_of(pc_q) == exit_q));

  // R6
  jump_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && jump_take) |=> (pc_q == $past(jump_tgt)));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !issue |=> $stable(pc_q));
endmodule

// File: rtl/loop_seq.sv
`timescale 1ns/1ps
module loop_seq
  import loop_seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          jump_take,
  input  logic [AW-1:0] jump_tgt,
  input  logic          rep_go,
  input  logic [AW-1:0] rep_len,
  input  logic [CW-1:0] rep_iter,
  input  logic          st_we,
  input  logic [1:0]    st_sel,
  input  logic [AW-1:0] st_addr,
  input  logic [CW-1:0] st_cnt,
  output logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] lp_start,
  output logic [AW-1:0] lp_exit,
  output logic [CW-1:0] lp_count,
  output logic          lp_active,
  output logic          loop_back
);
  logic          rep_fire;
  logic [AW-1:0] seq_addr;
  logic [AW-1:0] exit_nx;
  nxt_src_e      src;

  assign rep_fire = issue && rep_go && !jump_take;

  lseq_pc #(.AW(AW)) u_pc (
    .clk(clk), .rst(rst), .issue(issue), .jump_take(jump_take),
    .jump_tgt(jump_tgt), .rep_go(rep_go), .active(lp_active),
    .start(lp_start), .exit_q(lp_exit), .exit_nx(exit_nx),
    .pc_q(fetch_pc), .seq_addr(seq_addr), .loop_back(loop_back), .src(src)
  );

  lseq_state #(.AW(AW), .CW(CW)) u_state (
    .clk(clk), .rst(rst), .rep_fire(rep_fire), .rep_base(seq_addr),
    .rep_len(rep_len), .rep_iter(rep_iter), .loop_back(loop_back),
    .st_we(st_we), .st_sel(st_sel), .st_addr(st_addr), .st_cnt(st_cnt),
    .start_q(lp_start), .exit_q(lp_exit), .count_q(lp_count),
    .active_q(lp_active), .exit_nx(exit_nx)
  );

  // R3
  repeat_arms_chk: assert property (@(posedge clk) disable iff (rst)
    (rep_fire && !st_we) |=> (lp_start == $past(fetch_pc) + AW'(1)));

  // R4
  loop_src_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({loop_back, rep_fire, issue && jump_take}));

  // R4
  loop_src_agrees_chk: assert property (@(posedge clk) disable iff (rst)
    loop_back == (src == SRC_LOOP));
endmodule

// File: tb/sim_loop_seq.sv
`timescale 1ns/1ps
module sim_loop_seq;
  logic       clk = 1'b0;
  logic       rst;
  logic       issue, jump_take, rep_go, st_we;
  logic [7:0] jump_tgt, rep_len, rep_iter, st_addr, st_cnt;
  logic [1:0] st_sel;
  logic [7:0] fetch_pc, lp_start, lp_exit, lp_count;
  logic       lp_active, loop_back;

  int n_run = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  loop_seq u0 (
    .clk(clk), .rst(rst), .issue(issue), .jump_take(jump_take),
    .jump_tgt(jump_tgt), .rep_go(rep_go), .rep_len(rep_len),
    .rep_iter(rep_iter), .st_we(st_we), .st_sel(st_sel),
    .st_addr(st_addr), .st_cnt(st_cnt), .fetch_pc(fetch_pc),
    .lp_start(lp_start), .lp_exit(lp_exit), .lp_count(lp_count),
    .lp_active(lp_active), .loop_back(loop_back)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    issue = 0; jump_take = 0; jump_tgt = 0; rep_go = 0; rep_len = 0;
    rep_iter = 0; st_we = 0; st_sel = 0; st_addr = 0; st_cnt = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    clear_in();
  endtask

  task automatic step();
    issue = 1; tick();
  endtask

  task automatic idle();
    tick();
  endtask

  task automatic jump(input int t);
    issue = 1; jump_take = 1; jump_tgt = 8'(t); tick();
  endtask

  task automatic rep(input int l, input int n);
    issue = 1; rep_go = 1; rep_len = 8'(l); rep_iter = 8'(n); tick();
  endtask

  task automatic wr(input int sel, input int a, input int c);
    st_we = 1; st_sel = 2'(sel); st_addr = 8'(a); st_cnt = 8'(c); tick();
  endtask

  task automatic do_reset();
    clear_in(); rst = 1; tick(); tick(); rst = 0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 0;
    clear_in();
    @(negedge clk);
    // R1 reset state
    do_reset();
    check("R1 pc", fetch_pc, 0);
    check("R1 start", lp_start, 0);
    check("R1 exit", lp_exit, 0);
    check("R1 count", lp_count, 0);
    check("R1 active", lp_active, 0);

    // R2 sequential and hold
    step(); step(); step();
    check("R2 seq", fetch_pc, 3);
    idle(); idle();
    check("R2 hold", fetch_pc, 3);

    // R3 R4 R5 R8 sweep over lengths and counts
    for (int n = 0; n <= 5; n++) begin
      for (int l = 0; l <= 4; l++) begin
        int passes;
        bit arm;
        do_reset();
        step(); step(); step();
        rep(l, n);
        arm = (n > 1) && (l > 0);
        passes = arm ? n : 1;
        check("R3 start", lp_start, 4);
        check("R3 exit", lp_exit, 4 + l);
        check("R3 pc", fetch_pc, 4);
        check(arm ? "R3 count" : "R8 count", lp_count, arm ? n - 1 : 0);
        check(arm ? "R3 active" : "R8 active", lp_active, arm ? 1 : 0);
        for (int p = 0; p < passes; p++) begin
          for (int k = 0; k < l; k++) begin
            check("R4 body pc", fetch_pc, 4 + k);
            step();
          end
          if (p < passes - 1) begin
            check("R4 count", lp_count, n - 2 - p);
          end
        end
        check("R5 fall pc", fetch_pc, 4 + l);
        check("R5 count", lp_count, 0);
        check("R5 active", lp_active, 0);
      end
    end

    // R6 R7 jumps
    do_reset();
    rep(4, 3);                      // body 1..4, exit 5, count 2
    step(); step(); step();
    check("R7 at last", fetch_pc, 4);
    jump(40);
    check("R6 jump pc", fetch_pc, 40);
    check("R6 count kept", lp_count, 2);
    step();
    jump(4);                        // land directly on last body instr
    step();
    check("R7 loop after land", fetch_pc, 1);
    check("R7 count", lp_count, 1);
    jump(30); step(); jump(2);      // leave the body and come back
    step(); step(); step();
    check("R7 loop after exit", fetch_pc, 1);
    check("R7 count 0", lp_count, 0);
    step(); step(); step(); step();
    check("R5 after jumps", fetch_pc, 5);

    // R9 state writes
    do_reset();
    wr(0, 33, 0);
    check("R9 start", lp_start, 33);
    wr(1, 44, 0);
    check("R9 exit", lp_exit, 44);
    wr(2, 0, 6);
    check("R9 count", lp_count, 6);
    check("R9 active", lp_active, 1);
    wr(3, 99, 99);
    check("R9 sel3 start", lp_start, 33);
    check("R9 sel3 exit", lp_exit, 44);
    check("R9 sel3 count", lp_count, 6);
    check("R9 sel3 pc", fetch_pc, 0);
    wr(2, 0, 0);
    check("R9 clear active", lp_active, 0);
    issue = 1; rep_go = 1; rep_len = 3; rep_iter = 4;
    st_we = 1; st_sel = 2; st_cnt = 7; tick();
    check("R9 override count", lp_count, 7);
    check("R9 override start", lp_start, 1);

    // R10 counted breakpoint: exit 20, start 21, three skips
    do_reset();
    jump(16);
    wr(0, 21, 0); wr(1, 20, 0); wr(2, 0, 3);
    jump(18);
    for (int p = 0; p <= 3; p++) begin
      step();
      check("R10 pre", fetch_pc, 19);
      step();
      if (p < 3) begin
        check("R10 skip", fetch_pc, 21);
        check("R10 count", lp_count, 2 - p);
        jump(18);
      end else begin
        check("R10 fall in", fetch_pc, 20);
        check("R10 inactive", lp_active, 0);
      end
    end

    // R11 save and restore
    do_reset();
    rep(3, 4);                      // body 1..3, exit 4, count 3
    step(); step(); step();
    check("R11 first pass", fetch_pc, 1);
    begin
      int s_st, s_ex, s_ct;
      s_st = lp_start; s_ex = lp_exit; s_ct = lp_count;
      wr(0, 50, 0); wr(1, 60, 0); wr(2, 0, 0);
      check("R11 clobber", lp_active, 0);
      jump(10); step(); step();
      wr(0, s_st, 0); wr(1, s_ex, 0); wr(2, 0, s_ct);
      check("R11 restored count", lp_count, 2);
      jump(1);
      for (int i = 0; i < 9; i++) step();
      check("R11 resume fall", fetch_pc, 4);
      check("R11 resume count", lp_count, 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule